// File: doc/BRIEF.md
# Programmable Handshake Parallel Port

This block is one 8-bit parallel port. A CPU programs it through a small register interface and moves data through it; a peripheral exchanges bytes with it over a strobe/ready handshake. The CPU side has a control/data select, level-sensitive write and read strobes, and separate 8-bit write and read buses. The peripheral side has an 8-bit bus in each direction with a per-line output enable, an active-low strobe input and an active-high ready output.

Control writes are told apart by the pattern in their low bits. They load the interrupt vector, select one of four modes (output, input, bidirectional-output, bit control), load the per-line direction register, or set the interrupt enable. Some control words claim the control word that follows them. In the three handshake modes the port runs the ready/strobe protocol. It latches input data while the strobe is low. It raises a pending interrupt on the strobe's rising edge, which it sees after a synchroniser on the single system clock. The request leaves the port only while interrupts are enabled.

Top module: `hsk_port`

## Requirements
- R1: A control write with bit 0 = 0 loads bits 7..1 into the vector register. A control read returns the vector with bit 0 forced to 0. A synchronous reset leaves the vector unchanged.
- R2: A control write whose low nibble is 1111 selects the mode from bits 7..6 (00 output, 01 input, 10 bidirectional, 11 bit control), and bits 5..4 have no effect. In output mode per_oe is 8'hFF; in input mode it is 8'h00.
- R3: After bit-control mode is selected, the next control write is the direction word, where a 1 makes that line an input. In bit-control mode per_oe is the inverse of the direction word. A data read returns per_in on input lines and the output register on output lines.
- R4: A control write with low nibble 0111 sets the interrupt enable from bit 7. If its bit 4 is set, it clears any pending request and the next control write is taken as the mask word and decodes as nothing else. A control write with low nibble 0011 changes only the enable, from bit 7.
- R5: In output mode, a data write loads per_out and ready is high from the second clock after the write ends. The strobe's rising edge clears ready and sets the pending request.
- R6: In input mode, a data read arms ready. While the strobe is low, per_in is latched into the input register, which data reads return. The strobe's rising edge clears ready and sets the pending request.
- R7: If ready is high when a data write (output mode) or data read (input mode) starts, ready is low from the clock after the access starts until the clock after it ends, and then it is high again.
- R8: In bidirectional mode the output register drives per_out and per_oe is 8'hFF only while per_stb_n is low; otherwise per_oe is 8'h00. Ready follows the output-mode handshake.
- R9: In bit-control mode the strobe has no effect: ready stays low and no request becomes pending.
- R10: Reset selects input mode, clears the output register, the interrupt enable, the pending request and ready, and floats the port (per_oe = 0).
- R11: A request that becomes pending while the enable is 0 is held. irq rises once the enable is set, and it is the logical AND of the pending request and the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel_ctrl | input | 1 | 1 selects control access, 0 selects data |
| cpu_wr | input | 1 | Write access, held high for the access |
| cpu_rd | input | 1 | Read access, held high for the access |
| cpu_wdata | input | 8 | Write bus |
| cpu_rdata | output | 8 | Read bus |
| per_in | input | 8 | Peripheral bus, inbound |
| per_out | output | 8 | Peripheral bus, outbound |
| per_oe | output | 8 | Per-line output enable for per_out |
| per_stb_n | input | 1 | Peripheral strobe, active low |
| per_rdy | output | 1 | Ready to the peripheral |
| irq | output | 1 | Interrupt request, active high |

## Verification
Random bytes flow through output mode and input mode. These runs show whether the data path loses or swaps bits, and whether the handshake re-arms on every transfer. Directed control words with junk in the ignored mode bits, and a mode word sent where the mask word belongs, test that decoding looks at the low-bit signature and the word sequence. Long accesses made while ready is high show the forced-low window. Mixed direction words in bit-control mode, and strobe pulses there and in bidirectional mode, check the per-line merge and that the bus is driven only while the strobe is low.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int unsigned PORT_W = 8;

    typedef enum logic [1:0] {
        MODE_OUT   = 2'd0,
        MODE_IN    = 2'd1,
        MODE_BIDIR = 2'd2,
        MODE_BIT   = 2'd3
    } port_mode_e;

    typedef enum logic [1:0] {
        EXP_CMD   = 2'd0,
        EXP_IOSEL = 2'd1,
        EXP_MASK  = 2'd2
    } ctl_expect_e;

    typedef struct packed {
        port_mode_e          mode;
        logic [PORT_W-1:0]   io_sel;
        logic                ien;
    } port_cfg_t;

    function automatic logic is_vector_word(input logic [PORT_W-1:0] w);
        return ~w[0];
    endfunction

    function automatic logic is_mode_word(input logic [PORT_W-1:0] w);
        return w[3:0] == 4'b1111;
    endfunction

    function automatic logic is_intctl_word(input logic [PORT_W-1:0] w);
        return w[3:0] == 4'b0111;
    endfunction

    function automatic logic is_ien_word(input logic [PORT_W-1:0] w);
        return w[3:0] == 4'b0011;
    endfunction

    function automatic logic [PORT_W-1:0] bit_merge(input logic [PORT_W-1:0] pins,
                                                    input logic [PORT_W-1:0] outr,
                                                    input logic [PORT_W-1:0] dir);
        return (pins & dir) | (outr & ~dir);
    endfunction

    function automatic logic uses_handshake(input port_mode_e m);
        return m != MODE_BIT;
    endfunction

    function automatic logic drives_on_write(input port_mode_e m);
        return (m == MODE_OUT) || (m == MODE_BIDIR);
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/hsk_ctrl_dec.sv
module hsk_ctrl_dec
    import hsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [PORT_W-1:0] wdata,
    output port_cfg_t         cfg,
    output logic [PORT_W-1:0] vector,
    output logic              mode_wr,
    output logic              clr_pend
);
    ctl_expect_e       expect_q;
    logic [PORT_W-1:1] vec_q;
    logic              cmd_slot;

    assign cmd_slot = ctl_wr && (expect_q == EXP_CMD);
    assign mode_wr  = cmd_slot && is_mode_word(wdata);
    assign clr_pend = cmd_slot && is_intctl_word(wdata) && wdata[4];
    assign vector   = {vec_q, 1'b0};

    always_ff @(posedge clk) begin
        if (cmd_slot && is_vector_word(wdata)) vec_q <= wdata[PORT_W-1:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_q   <= EXP_CMD;
            cfg.mode   <= MODE_IN;
            cfg.io_sel <= '1;
            cfg.ien    <= 1'b0;
        end else if (ctl_wr) begin
            unique case (expect_q)
                EXP_IOSEL: begin
                    cfg.io_sel <= wdata;
                    expect_q   <= EXP_CMD;
                end
                EXP_MASK: begin
                    expect_q <= EXP_CMD;
                end
                default: begin
                    if (is_mode_word(wdata)) begin
                        cfg.mode <= port_mode_e'(wdata[7:6]);
                        if (port_mode_e'(wdata[7:6]) == MODE_BIT) expect_q <= EXP_IOSEL;
                    end else if (is_intctl_word(wdata)) begin
                        cfg.ien <= wdata[7];
                        if (wdata[4]) expect_q <= EXP_MASK;
                    end else if (is_ien_word(wdata)) begin
                        cfg.ien <= wdata[7];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hsk_handshake.sv
module hsk_handshake
    import hsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_mode_e        mode,
    input  logic              wr_start,
    input  logic              rd_start,
    input  logic              wr_act,
    input  logic              rd_act,
    input  logic              stb_rise,
    input  logic              stb_low,
    input  logic              mode_wr,
    input  logic              clr_pend,
    input  logic [PORT_W-1:0] pins,
    output logic              rdy,
    output logic              pend,
    output logic [PORT_W-1:0] in_reg
);
    logic hs, arm_q, arm_nxt, arm_set, acc;

    assign hs      = uses_handshake(mode);
    assign arm_set = (drives_on_write(mode) && wr_start) || (mode == MODE_IN && rd_start);
    assign acc     = (drives_on_write(mode) && wr_act) || (mode == MODE_IN && rd_act);

    always_comb begin
        arm_nxt = arm_q;
        if (hs && stb_rise) arm_nxt = 1'b0;
        if (arm_set)        arm_nxt = 1'b1;
        if (mode_wr)        arm_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            rdy    <= 1'b0;
            pend   <= 1'b0;
            in_reg <= '0;
        end else begin
            arm_q <= arm_nxt;
            rdy   <= arm_nxt && !acc && hs;
            if (hs && stb_rise)     pend <= 1'b1;
            else if (clr_pend)      pend <= 1'b0;
            if (hs && stb_low && mode != MODE_OUT) in_reg <= pins;
        end
    end
endmodule

// File: rtl/hsk_port.sv
module hsk_port
    import hsk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_sel_ctrl,
    input  logic        cpu_wr,
    input  logic        cpu_rd,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    input  logic [7:0]  per_in,
    output logic [7:0]  per_out,
    output logic [7:0]  per_oe,
    input  logic        per_stb_n,
    output logic        per_rdy,
    output logic        irq
);
    port_cfg_t         cfg;
    port_mode_e        cur_mode;
    logic [PORT_W-1:0] vector, out_reg, in_reg;
    logic              wr_q, rd_q, wr_start, rd_start, dwr_act, drd_act;
    logic              stb_level, stb_rise, mode_wr, clr_pend, pend;

    assign cur_mode = cfg.mode;
    assign wr_start = cpu_wr && !wr_q;
    assign rd_start = cpu_rd && !rd_q;
    assign dwr_act  = cpu_wr && !cpu_sel_ctrl;
    assign drd_act  = cpu_rd && !cpu_sel_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            out_reg <= '0;
        end else begin
            wr_q <= cpu_wr;
            rd_q <= cpu_rd;
            if (wr_start && !cpu_sel_ctrl) out_reg <= cpu_wdata;
        end
    end

    hsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(per_stb_n), .level(stb_level), .rise(stb_rise)
    );

    hsk_ctrl_dec u_dec (
        .clk(clk), .rst(rst), .ctl_wr(wr_start && cpu_sel_ctrl), .wdata(cpu_wdata),
        .cfg(cfg), .vector(vector), .mode_wr(mode_wr), .clr_pend(clr_pend)
    );

    hsk_handshake u_hs (
        .clk(clk), .rst(rst), .mode(cfg.mode),
        .wr_start(wr_start && !cpu_sel_ctrl), .rd_start(rd_start && !cpu_sel_ctrl),
        .wr_act(dwr_act), .rd_act(drd_act),
        .stb_rise(stb_rise), .stb_low(!stb_level),
        .mode_wr(mode_wr), .clr_pend(clr_pend), .pins(per_in),
        .rdy(per_rdy), .pend(pend), .in_reg(in_reg)
    );

    assign irq     = pend && cfg.ien;
    assign per_out = out_reg;

    always_comb begin
        unique case (cfg.mode)
            MODE_OUT:   per_oe = '1;
            MODE_IN:    per_oe = '0;
            MODE_BIDIR: per_oe = {PORT_W{~per_stb_n}};
            default:    per_oe = ~cfg.io_sel;
        endcase
    end

    always_comb begin
        if (cpu_sel_ctrl) begin
            cpu_rdata = vector;
        end else begin
            unique case (cfg.mode)
                MODE_OUT: cpu_rdata = out_reg;
                MODE_BIT: cpu_rdata = bit_merge(per_in, out_reg, cfg.io_sel);
                default:  cpu_rdata = in_reg;
            endcase
        end
    end
endmodule

// File: rtl/hsk_port_chk.sv
module hsk_port_chk
    import hsk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic       cpu_sel_ctrl,
    input logic       per_stb_n,
    input logic       per_rdy,
    input logic       irq,
    input logic [7:0] per_oe,
    input port_mode_e mode
);
    assert_rdy_low_bitmode_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BIT && $past(mode == MODE_BIT)) |-> !per_rdy);

    assert_float_in_input_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IN) |-> (per_oe == 8'h00));

    assert_bidir_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BIDIR && per_stb_n) |-> (per_oe == 8'h00));

    assert_rdy_forced_low_R7: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_wr && !cpu_sel_ctrl && mode == MODE_OUT) |-> !per_rdy);

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (per_oe == 8'h00 && !irq && !per_rdy));
endmodule

bind hsk_port hsk_port_chk u_chk (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_sel_ctrl(cpu_sel_ctrl),
    .per_stb_n(per_stb_n), .per_rdy(per_rdy), .irq(irq), .per_oe(per_oe), .mode(cur_mode)
);

// File: tb/tb_hsk_port.sv
module tb_hsk_port;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_sel_ctrl = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata, per_in = '0, per_out, per_oe;
    logic       per_stb_n = 1'b1, per_rdy, irq;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] rd_val;
    logic       rdy_mid;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsk_port dut (.*);

    function automatic logic [7:0] exp_merge(input logic [7:0] pins, input logic [7:0] o,
                                             input logic [7:0] dir);
        return (pins & dir) | (o & ~dir);
    endfunction

    function automatic logic [7:0] mode_word(input logic [1:0] m, input logic [1:0] junk);
        return {m, junk, 4'hF};
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic ctl, input logic [7:0] d, input int len);
        @(negedge clk);
        cpu_sel_ctrl = ctl; cpu_wdata = d; cpu_wr = 1'b1;
        for (int i = 0; i < len; i++) @(negedge clk);
        rdy_mid = per_rdy;
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic ctl, input int len);
        @(negedge clk);
        cpu_sel_ctrl = ctl; cpu_rd = 1'b1;
        for (int i = 0; i < len; i++) @(negedge clk);
        rd_val = cpu_rdata; rdy_mid = per_rdy;
        cpu_rd = 1'b0;
    endtask

    task automatic strobe(input int low_cycles);
        @(negedge clk); per_stb_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        per_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_pending();
        cpu_write(1, 8'h97, 1);
        cpu_write(1, 8'hFF, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        v = 8'($urandom(32'd7));
        do_reset();

        // R10: reset state
        check(per_oe == 8'h00 && !per_rdy && !irq, "R10 reset", {per_oe[6:0], per_rdy}, 8'h00);

        // R1: vector load, bit0 reads 0, survives reset
        cpu_write(1, 8'hA4, 1);
        cpu_read(1, 1);
        check(rd_val == 8'hA4, "R1 vector", rd_val, 8'hA4);
        cpu_write(0, 8'h77, 1);
        do_reset();
        cpu_read(1, 1);
        check(rd_val == 8'hA4, "R1 vector kept over reset", rd_val, 8'hA4);
        cpu_write(1, mode_word(2'b00, 2'b00), 1);
        cpu_read(0, 1);
        check(rd_val == 8'h00, "R10 output register cleared", rd_val, 8'h00);

        // R2: junk in bits 5..4 ignored
        cpu_write(1, mode_word(2'b01, 2'b00), 1);
        @(negedge clk);
        check(per_oe == 8'h00, "R2 input mode floats", per_oe, 8'h00);
        cpu_write(1, mode_word(2'b00, 2'b11), 1);
        @(negedge clk);
        check(per_oe == 8'hFF, "R2 output mode with junk bits", per_oe, 8'hFF);

        // R11: pending held while disabled
        cpu_write(0, 8'h3C, 1);
        strobe(2);
        check(!irq, "R11 held while disabled", {7'd0, irq}, 8'h00);
        cpu_write(1, 8'h83, 1);
        @(negedge clk);
        check(irq, "R11 presented on enable", {7'd0, irq}, 8'h01);

        // R4: mask-follows clears pending and swallows next word
        cpu_write(1, mode_word(2'b01, 2'b00), 1);
        cpu_write(1, 8'h97, 1);
        @(negedge clk);
        check(!irq, "R4 pending cleared", {7'd0, irq}, 8'h00);
        cpu_write(1, mode_word(2'b00, 2'b00), 1);
        @(negedge clk);
        check(per_oe == 8'h00, "R4 mask word not decoded as mode", per_oe, 8'h00);
        cpu_write(1, 8'h03, 1);
        strobe(1);
        check(!irq, "R4 enable-only word clears enable", {7'd0, irq}, 8'h00);
        cpu_write(1, 8'h83, 1);
        @(negedge clk);
        check(irq, "R4 enable-only word sets enable", {7'd0, irq}, 8'h01);

        // R5 random output transfers
        cpu_write(1, mode_word(2'b00, 2'b00), 1);
        for (int i = 0; i < 16; i++) begin
            v = 8'($urandom);
            clear_pending();
            cpu_write(0, v, 1);
            @(negedge clk);
            check(per_out == v && per_rdy, "R5 output data and ready", per_out, v);
            strobe(1 + (i % 3));
            check(!per_rdy && irq, "R5 strobe clears ready, requests", {6'd0, per_rdy, irq}, 8'h01);
        end

        // R7 output forced low
        cpu_write(0, 8'h11, 1);
        @(negedge clk);
        cpu_write(0, 8'h22, 3);
        check(!rdy_mid, "R7 output ready low during write", {7'd0, rdy_mid}, 8'h00);
        @(negedge clk);
        check(per_rdy && per_out == 8'h22, "R7 output ready back high", {7'd0, per_rdy}, 8'h01);

        // R6 random input transfers
        cpu_write(1, mode_word(2'b01, 2'b00), 1);
        for (int i = 0; i < 16; i++) begin
            v = 8'($urandom);
            clear_pending();
            cpu_read(0, 1);
            @(negedge clk);
            check(per_rdy, "R6 read arms ready", {7'd0, per_rdy}, 8'h01);
            per_in = v;
            strobe(1 + (i % 2));
            check(!per_rdy && irq, "R6 strobe clears ready, requests", {6'd0, per_rdy, irq}, 8'h01);
            cpu_read(0, 1);
            check(rd_val == v, "R6 latched data", rd_val, v);
        end

        // R7 input forced low
        @(negedge clk);
        cpu_read(0, 3);
        check(!rdy_mid, "R7 input ready low during read", {7'd0, rdy_mid}, 8'h00);
        @(negedge clk);
        check(per_rdy, "R7 input ready back high", {7'd0, per_rdy}, 8'h01);

        // R8 bidirectional
        cpu_write(1, mode_word(2'b10, 2'b01), 1);
        clear_pending();
        cpu_write(0, 8'h5A, 1);
        @(negedge clk);
        check(per_oe == 8'h00 && per_rdy, "R8 bus floats while strobe high", per_oe, 8'h00);
        per_stb_n = 1'b0;
        @(negedge clk);
        check(per_oe == 8'hFF && per_out == 8'h5A, "R8 drives while strobe low", per_oe, 8'hFF);
        per_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        check(per_oe == 8'h00 && !per_rdy && irq, "R8 after strobe", {per_oe[6:0], per_rdy}, 8'h00);

        // R3 / R9 bit control
        cpu_write(1, mode_word(2'b11, 2'b00), 1);
        cpu_write(1, 8'hF0, 1);
        clear_pending();
        cpu_write(0, 8'h3C, 1);
        per_in = 8'hA5;
        @(negedge clk);
        check(per_oe == 8'h0F, "R3 direction word", per_oe, 8'h0F);
        cpu_read(0, 1);
        check(rd_val == exp_merge(8'hA5, 8'h3C, 8'hF0), "R3 merged read", rd_val,
              exp_merge(8'hA5, 8'h3C, 8'hF0));
        strobe(2);
        check(!per_rdy && !irq, "R9 strobe ignored", {6'd0, per_rdy, irq}, 8'h00);

        // R10 again: reset from bit mode
        do_reset();
        check(per_oe == 8'h00 && !per_rdy && !irq, "R10 reset from bit mode", per_oe, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule